// File: doc/BRIEF.md
# PTP Event Frame Timestamp Unit

This block sits beside an Ethernet media stream, on either the receive or the transmit side, and picks out precision-time-protocol event frames. It accepts either a 4-bit nibble stream or an 8-bit byte stream and copies the external real-time clock value at the start delimiter. Once the frame has been parsed far enough to confirm that it is a selected PTP message, it writes a 128-bit record into a small queue.

The parser works on 32-bit words that are assembled from the media bytes. In byte mode that means one word every four clocks. A host-supplied 16-bit type mask selects which message types produce records. The host drains the queue one record at a time with a request/acknowledge handshake. A sticky flag shows that a record was lost because the queue was full.

Top module: `ptp_stamp_unit`

## Requirements
- R1: While reset is held and right after it, `rd_ack` is 0, `q_count` is 0 and `overflow` is 0.
- R2: In byte mode (`mii_mode`=0), a frame starts after at least seven 0x55 bytes followed by 0xD5, all with `rx_dv` high. The record holds the `time_sec`/`time_ns` values sampled on the clock edge that accepts the 0xD5 byte.
- R3: In nibble mode (`mii_mode`=1), each byte arrives as two `rx_d[3:0]` nibbles, low nibble first. The time is sampled on the edge that accepts the high nibble of 0xD5.
- R4: A delimiter that follows fewer than seven 0x55 bytes starts no frame, and no record is written.
- R5: A frame whose bytes 12 and 13 after the delimiter are not 0x88 and 0xF7 gives no record.
- R6: The message type is the low nibble of byte 14 after the delimiter. A record is written only when `type_mask[type]` is 1.
- R7: Record layout: [127:112] zero, [111:64] seconds, [63:32] nanoseconds, [31:28] message type, [27:16] the low 12 bits of the sum of bytes 0..45 after the delimiter, [15:0] sequence ID taken from bytes 44 (high) and 45 (low).
- R8: When `rd_req` is sampled high, no acknowledge is pending and the queue is not empty, `rd_ack` is high for exactly one cycle on the next cycle, and `rd_data` then holds the oldest record. If the queue is empty, no acknowledge is given.
- R9: The queue holds `DEPTH` (default 4) records and hands them out in arrival order. `q_count` never exceeds `DEPTH`.
- R10: A record that arrives while the queue is full and no read pops in that cycle is dropped, and `overflow` is set. `ovf_clr` clears `overflow`, but a drop in the same cycle wins over the clear.
- R11: A record that arrives while the queue is full, in the same cycle as a read pop, is accepted, and `overflow` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Media clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_mode | input | 1 | 1 = nibble stream, 0 = byte stream |
| rx_dv | input | 1 | Media data valid |
| rx_d | input | 8 | Media data (bits 3:0 in nibble mode) |
| time_sec | input | 48 | Real-time clock seconds |
| time_ns | input | 32 | Real-time clock nanoseconds |
| type_mask | input | 16 | One enable bit per message type |
| rd_req | input | 1 | Host read request |
| rd_ack | output | 1 | One-cycle read acknowledge |
| rd_data | output | 128 | Record returned with rd_ack |
| q_count | output | CW | Records held in the queue |
| overflow | output | 1 | Sticky record-lost flag |
| ovf_clr | input | 1 | Clears overflow |

## Verification
Two things can land on the same clock edge: a parsed record being written into a full queue, and a host read popping it. The same edge can also carry a drop together with the host's clear of the overflow flag. The bench fills the queue and counts the edges from the last frame byte to the record write. It then raises `rd_req` or `ovf_clr` so that it is sampled on exactly that edge. It judges the result by `q_count`, by `overflow`, and by the order in which the scoreboard sees the records come back.

// File: rtl/ptp_su_pkg.sv
package ptp_su_pkg;
  localparam int SEC_W   = 48;
  localparam int NS_W    = 32;
  localparam int ENTRY_W = 128;
  localparam logic [15:0] PTP_ETYPE = 16'h88F7;
  localparam logic [7:0]  PRE_BYTE  = 8'h55;
  localparam logic [7:0]  SFD_BYTE  = 8'hD5;
  localparam logic [2:0]  PRE_MIN   = 3'd7;
  localparam logic [3:0]  ET_WORD   = 4'd3;
  localparam logic [3:0]  SEQ_WORD  = 4'd11;

  typedef struct packed {
    logic [15:0]     pad;
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
    logic [3:0]      mtype;
    logic [11:0]     csum;
    logic [15:0]     seq;
  } stamp_t;
endpackage

// File: rtl/ptp_su_rxfront.sv
module ptp_su_rxfront
  import ptp_su_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mii_mode,
  input  logic              dv,
  input  logic [7:0]        d,
  input  logic [SEC_W-1:0]  t_sec,
  input  logic [NS_W-1:0]   t_ns,
  output logic              word_vld,
  output logic [31:0]       word,
  output logic [3:0]        word_idx,
  output logic [SEC_W-1:0]  ts_sec,
  output logic [NS_W-1:0]   ts_ns
);
  logic [3:0]  nib_q, nib_d;
  logic        phase_q, phase_d;
  logic [2:0]  pre_q, pre_d;
  logic        inf_q, inf_d;
  logic [1:0]  bcnt_q, bcnt_d;
  logic [23:0] sh_q, sh_d;
  logic [3:0]  widx_q, widx_d;
  logic        wvld_q, wvld_d;
  logic [31:0] word_q, word_d;
  logic [3:0]  idx_q, idx_d;
  logic [SEC_W-1:0] tss_q, tss_d;
  logic [NS_W-1:0]  tsn_q, tsn_d;

  logic       byte_vld, sof, body;
  logic [7:0] byte_val;

  // Byte assembly: nibble mode completes a byte on every second valid cycle.
  assign byte_vld = dv && (!mii_mode || phase_q);
  assign byte_val = mii_mode ? {d[3:0], nib_q} : d;
  assign sof  = byte_vld && !inf_q && (byte_val == SFD_BYTE) && (pre_q == PRE_MIN);
  assign body = byte_vld && inf_q;

  always_comb begin
    nib_d = nib_q; phase_d = phase_q; pre_d = pre_q; inf_d = inf_q;
    bcnt_d = bcnt_q; sh_d = sh_q; widx_d = widx_q; wvld_d = 1'b0;
    word_d = word_q; idx_d = idx_q; tss_d = tss_q; tsn_d = tsn_q;
    if (!dv) begin
      phase_d = 1'b0; pre_d = '0; inf_d = 1'b0; bcnt_d = '0; widx_d = '0;
    end else begin
      if (mii_mode) begin
        phase_d = !phase_q;
        if (!phase_q) nib_d = d[3:0];
      end
      if (sof) begin
        inf_d = 1'b1; tss_d = t_sec; tsn_d = t_ns; bcnt_d = '0; widx_d = '0;
      end else if (body) begin
        bcnt_d = bcnt_q + 2'd1;
        sh_d   = {sh_q[15:0], byte_val};
        if (bcnt_q == 2'd3) begin
          wvld_d = 1'b1;
          word_d = {sh_q, byte_val};
          idx_d  = widx_q;
          if (widx_q != 4'hF) widx_d = widx_q + 4'd1;
        end
      end else if (byte_vld) begin
        if (byte_val == PRE_BYTE) pre_d = (pre_q == PRE_MIN) ? PRE_MIN : pre_q + 3'd1;
        else                      pre_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q <= '0; phase_q <= 1'b0; pre_q <= '0; inf_q <= 1'b0;
      bcnt_q <= '0; sh_q <= '0; widx_q <= '0; wvld_q <= 1'b0;
      word_q <= '0; idx_q <= '0; tss_q <= '0; tsn_q <= '0;
    end else begin
      nib_q <= nib_d; phase_q <= phase_d; pre_q <= pre_d; inf_q <= inf_d;
      bcnt_q <= bcnt_d; sh_q <= sh_d; widx_q <= widx_d; wvld_q <= wvld_d;
      word_q <= word_d; idx_q <= idx_d; tss_q <= tss_d; tsn_q <= tsn_d;
    end
  end

  assign word_vld = wvld_q;
  assign word     = word_q;
  assign word_idx = idx_q;
  assign ts_sec   = tss_q;
  assign ts_ns    = tsn_q;
endmodule

// File: rtl/ptp_su_parser.sv
module ptp_su_parser
  import ptp_su_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_vld,
  input  logic [31:0]        word,
  input  logic [3:0]         word_idx,
  input  logic [SEC_W-1:0]   ts_sec,
  input  logic [NS_W-1:0]    ts_ns,
  input  logic [15:0]        mask,
  output logic               push,
  output logic [ENTRY_W-1:0] entry
);
  logic        et_ok_q, et_ok_d;
  logic [3:0]  mt_q, mt_d;
  logic [11:0] cs_q, cs_d;
  logic        push_q, push_d;
  stamp_t      ent_q, ent_d;
  logic [11:0] wsum;

  // Only the two leading bytes of the sequence word belong to the sum.
  always_comb begin
    wsum = 12'(word[31:24]) + 12'(word[23:16]);
    if (word_idx != SEQ_WORD) wsum = wsum + 12'(word[15:8]) + 12'(word[7:0]);
  end

  always_comb begin
    et_ok_d = et_ok_q; mt_d = mt_q; cs_d = cs_q; push_d = 1'b0; ent_d = ent_q;
    if (word_vld) begin
      if (word_idx == 4'd0)           cs_d = wsum;
      else if (word_idx <= SEQ_WORD)  cs_d = cs_q + wsum;
      if (word_idx == ET_WORD) begin
        et_ok_d = (word[31:16] == PTP_ETYPE);
        mt_d    = word[11:8];
      end
      if (word_idx == SEQ_WORD) begin
        push_d      = et_ok_q && mask[mt_q];
        ent_d.pad   = '0;
        ent_d.sec   = ts_sec;
        ent_d.ns    = ts_ns;
        ent_d.mtype = mt_q;
        ent_d.csum  = cs_q + wsum;
        ent_d.seq   = word[31:16];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      et_ok_q <= 1'b0; mt_q <= '0; cs_q <= '0; push_q <= 1'b0; ent_q <= '0;
    end else begin
      et_ok_q <= et_ok_d; mt_q <= mt_d; cs_q <= cs_d; push_q <= push_d; ent_q <= ent_d;
    end
  end

  assign push  = push_q;
  assign entry = ent_q;
endmodule

// File: rtl/ptp_su_fifo.sv
module ptp_su_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 128,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          drop
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, wr;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  // A pop in the same cycle frees the slot the incoming record needs.
  assign wr    = push && (!full || pop);
  assign drop  = push && full && !pop;

  always_comb begin
    wp_d = wp_q; rp_d = rp_q; cnt_d = cnt_q;
    if (wr)  wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (wr && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !wr) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      wp_q <= wp_d; rp_q <= rp_d; cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem_q[wp_q] <= din;
  end

  assign dout  = mem_q[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/ptp_stamp_unit.sv
module ptp_stamp_unit
  import ptp_su_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mii_mode,
  input  logic               rx_dv,
  input  logic [7:0]         rx_d,
  input  logic [SEC_W-1:0]   time_sec,
  input  logic [NS_W-1:0]    time_ns,
  input  logic [15:0]        type_mask,
  input  logic               rd_req,
  output logic               rd_ack,
  output logic [ENTRY_W-1:0] rd_data,
  output logic [CW-1:0]      q_count,
  output logic               overflow,
  input  logic               ovf_clr
);
  logic               wvld, push, pop, empty, drop;
  logic [31:0]        wrd;
  logic [3:0]         widx;
  logic [SEC_W-1:0]   tss;
  logic [NS_W-1:0]    tsn;
  logic [ENTRY_W-1:0] ent, head;
  logic               ack_q, ack_d, ovf_q, ovf_d;
  logic [ENTRY_W-1:0] dat_q, dat_d;

  ptp_su_rxfront u_front (
    .clk(clk), .rst_n(rst_n), .mii_mode(mii_mode), .dv(rx_dv), .d(rx_d),
    .t_sec(time_sec), .t_ns(time_ns), .word_vld(wvld), .word(wrd),
    .word_idx(widx), .ts_sec(tss), .ts_ns(tsn)
  );

  ptp_su_parser u_parse (
    .clk(clk), .rst_n(rst_n), .word_vld(wvld), .word(wrd), .word_idx(widx),
    .ts_sec(tss), .ts_ns(tsn), .mask(type_mask), .push(push), .entry(ent)
  );

  ptp_su_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(ent), .pop(pop),
    .dout(head), .count(q_count), .empty(empty), .drop(drop)
  );

  assign pop = rd_req && !ack_q && !empty;

  always_comb begin
    ack_d = pop;
    dat_d = pop ? head : dat_q;
    ovf_d = drop ? 1'b1 : (ovf_clr ? 1'b0 : ovf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0; dat_q <= '0; ovf_q <= 1'b0;
    end else begin
      ack_q <= ack_d; dat_q <= dat_d; ovf_q <= ovf_d;
    end
  end

  assign rd_ack   = ack_q;
  assign rd_data  = dat_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/ptp_su_chk.sv
module ptp_su_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [15:0]   rd_pad,
  input logic [CW-1:0] q_count,
  input logic          overflow,
  input logic          ovf_clr
);
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rd_ack);
  p_ack_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> ($past(rd_req) && ($past(q_count) != '0)));
  p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> (rd_pad == 16'h0000));
  p_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == $past(q_count)) || (q_count == $past(q_count) + 1'b1) ||
    (q_count + 1'b1 == $past(q_count)));
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr) |=> overflow);
  p_ovf_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(q_count) == CW'(DEPTH)));
endmodule

bind ptp_stamp_unit ptp_su_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
  .rd_pad(rd_data[127:112]), .q_count(q_count), .overflow(overflow),
  .ovf_clr(ovf_clr)
);

// File: tb/ptp_stamp_unit_tb.sv
module ptp_stamp_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n, mii_mode, rx_dv, rd_req, ovf_clr;
  logic [7:0]   rx_d;
  logic [47:0]  time_sec;
  logic [31:0]  time_ns;
  logic [15:0]  type_mask;
  logic         rd_ack, overflow;
  logic [127:0] rd_data;
  logic [2:0]   q_count;

  int n_chk = 0, n_err = 0, n_ack = 0;
  bit finished = 1'b0;
  logic [7:0]   fr [48];
  logic [127:0] exp_q [$];

  localparam logic [47:0] JUNK_S = 48'h0BAD_0BAD_0BAD;
  localparam logic [31:0] JUNK_N = 32'hBAD0_BAD0;

  always #10 clk = ~clk;

  ptp_stamp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mii_mode(mii_mode), .rx_dv(rx_dv), .rx_d(rx_d),
    .time_sec(time_sec), .time_ns(time_ns), .type_mask(type_mask),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data), .q_count(q_count),
    .overflow(overflow), .ovf_clr(ovf_clr)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor: every acknowledge is compared with the oldest expected record (R7, R8, R9).
  always @(negedge clk) begin
    if (rst_n && rd_ack) begin
      n_ack++;
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected ack", rd_data, 128'h0);
      else begin
        logic [127:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R7/R9 record", rd_data, e);
      end
    end
  end

  task automatic build(input logic [15:0] et, input logic [7:0] b14, input logic [15:0] seq, input logic [7:0] seed);
    for (int i = 0; i < 48; i++) fr[i] = seed + 8'(i * 7);
    fr[12] = et[15:8]; fr[13] = et[7:0]; fr[14] = b14;
    fr[44] = seq[15:8]; fr[45] = seq[7:0];
  endtask

  task automatic expect_rec(input logic [47:0] s, input logic [31:0] n);
    logic [11:0] cs;
    cs = '0;
    for (int i = 0; i < 46; i++) cs = cs + 12'(fr[i]);
    exp_q.push_back({16'h0, s, n, fr[14][3:0], cs, fr[44], fr[45]});
  endtask

  task automatic put_byte(input logic [7:0] b, input bit sfd, input logic [47:0] s, input logic [31:0] n);
    if (!mii_mode) begin
      @(negedge clk); rx_dv = 1'b1; rx_d = b;
      time_sec = sfd ? s : JUNK_S; time_ns = sfd ? n : JUNK_N;
    end else begin
      @(negedge clk); rx_dv = 1'b1; rx_d = {4'h0, b[3:0]};
      time_sec = JUNK_S; time_ns = JUNK_N;
      @(negedge clk); rx_d = {4'h0, b[7:4]};
      time_sec = sfd ? s : JUNK_S; time_ns = sfd ? n : JUNK_N;
    end
  endtask

  task automatic send(input int npre, input logic [47:0] s, input logic [31:0] n);
    for (int i = 0; i < npre; i++) put_byte(8'h55, 1'b0, s, n);
    put_byte(8'hD5, 1'b1, s, n);
    for (int i = 0; i < 48; i++) put_byte(fr[i], 1'b0, s, n);
    @(negedge clk); rx_dv = 1'b0; rx_d = 8'h00;
    time_sec = JUNK_S; time_ns = JUNK_N;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic read_one();
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int acks;
    rst_n = 1'b0; mii_mode = 1'b0; rx_dv = 1'b0; rx_d = '0; rd_req = 1'b0;
    ovf_clr = 1'b0; type_mask = 16'hFFFF; time_sec = JUNK_S; time_ns = JUNK_N;
    repeat (3) @(negedge clk);
    check(rd_ack == 1'b0 && q_count == 3'd0 && overflow == 1'b0, "R1 reset", {rd_ack, q_count, overflow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_ack == 1'b0 && q_count == 3'd0 && overflow == 1'b0, "R1 after reset", {rd_ack, q_count, overflow}, 0);

    // R2: byte mode, time taken at the delimiter
    build(16'h88F7, 8'h30, 16'h0101, 8'h11);
    expect_rec(48'h0000_1234_5678, 32'h0ABC_DEF0);
    send(7, 48'h0000_1234_5678, 32'h0ABC_DEF0);
    settle();
    check(q_count == 3'd1, "R2 record stored", q_count, 1);
    read_one();
    check(exp_q.size() == 0, "R2 record returned", exp_q.size(), 0);

    // R3: nibble mode, longer preamble
    mii_mode = 1'b1;
    build(16'h88F7, 8'h01, 16'hBEEF, 8'h42);
    expect_rec(48'hAAAA_5555_0001, 32'h3B9A_C9FF);
    send(9, 48'hAAAA_5555_0001, 32'h3B9A_C9FF);
    settle();
    check(q_count == 3'd1, "R3 nibble record stored", q_count, 1);
    read_one();
    mii_mode = 1'b0;

    // R4: six preamble bytes only
    build(16'h88F7, 8'h00, 16'h0002, 8'h05);
    send(6, 48'h1, 32'h1);
    settle();
    check(q_count == 3'd0, "R4 short preamble ignored", q_count, 0);

    // R5: wrong EtherType
    build(16'h0800, 8'h00, 16'h0003, 8'h06);
    send(7, 48'h2, 32'h2);
    settle();
    check(q_count == 3'd0, "R5 other ethertype ignored", q_count, 0);

    // R6: type 3 masked out, type 2 (high nibble set) kept
    type_mask = 16'hFFF7;
    build(16'h88F7, 8'h03, 16'h0004, 8'h07);
    send(7, 48'h3, 32'h3);
    settle();
    check(q_count == 3'd0, "R6 masked type dropped", q_count, 0);
    build(16'h88F7, 8'hA2, 16'h0005, 8'h08);
    expect_rec(48'h0000_0000_0044, 32'h0000_0055);
    send(7, 48'h0000_0000_0044, 32'h0000_0055);
    settle();
    check(q_count == 3'd1, "R6 enabled type kept", q_count, 1);
    read_one();
    type_mask = 16'hFFFF;

    // R8: read on empty queue gives no acknowledge
    acks = n_ack;
    read_one();
    check(n_ack == acks, "R8 no ack when empty", n_ack, acks);

    // R9: fill to depth
    for (int k = 0; k < 4; k++) begin
      build(16'h88F7, 8'(k), 16'(16'h100 + k), 8'(8'h20 + k));
      expect_rec(48'(48'h500 + k), 32'(32'h600 + k));
      send(7, 48'(48'h500 + k), 32'(32'h600 + k));
    end
    settle();
    check(q_count == 3'd4, "R9 queue full", q_count, 4);

    // R10: drop while full sets the flag, clear removes it
    build(16'h88F7, 8'h00, 16'h0777, 8'h33);
    send(7, 48'h777, 32'h777);
    settle();
    check(q_count == 3'd4 && overflow == 1'b1, "R10 drop sets overflow", {q_count, overflow}, {3'd4, 1'b1});
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check(overflow == 1'b0, "R10 clear", overflow, 0);

    // R10: drop and clear on the same edge, drop wins
    build(16'h88F7, 8'h00, 16'h0888, 8'h34);
    send(7, 48'h888, 32'h888);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check(overflow == 1'b1, "R10 set wins over clear", overflow, 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;

    // R11: record arrives on full queue on the same edge as a pop
    build(16'h88F7, 8'h09, 16'h0999, 8'h35);
    expect_rec(48'h999, 32'h999);
    send(7, 48'h999, 32'h999);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    settle();
    check(q_count == 3'd4 && overflow == 1'b0, "R11 push with pop accepted", {q_count, overflow}, {3'd4, 1'b0});

    // R9: drain in order
    for (int k = 0; k < 4; k++) read_one();
    check(q_count == 3'd0 && exp_q.size() == 0, "R9 drained in order", {q_count, 8'(exp_q.size())}, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule